// File: doc/BRIEF.md
# Four-Way Request Arbiter with Hold Timeout

This block shares one resource among four requesters. Each requester raises its own request line and gets a matching grant line back. At most one grant is high at any moment. A grant lasts while its request stays high, and is cut off when the request falls or when the holder has had the resource for eight clock cycles, whichever comes first.

After any release, the line that just lost the grant is kept out of the next selection, so a requester that holds its request high cannot get straight back in. When several requesters are eligible, the winner is chosen round-robin. The search starts at the index after the most recently granted line.

All state changes on the rising clock edge, apart from an asynchronous, active-high reset that returns the block to idle.

Top module: `grant_timeout_arb`

## Requirements
- R1: Asserting `rst` drives every grant low at once, without waiting for a clock edge. After reset the round-robin search starts at index 0.
- R2: When no grant is active and an eligible request is high, a grant rises on the next rising edge. Grant bit i always answers request bit i (bit 0 is requester 0).
- R3: At most one bit of `grant` is high in any cycle.
- R4: An active grant falls on the edge at which its own request is sampled low. No new grant is issued on that same edge.
- R5: A grant whose request stays high is held for exactly 8 cycles and then released by the timeout.
- R6: The line released on one edge is excluded from the selection on the next edge. If it is the only requester, no grant is given on that edge, and the line is granted on the edge after.
- R7: Among the eligible requests, the winner is the first one found searching upward, with wrap-around, from the index one above the last granted line.
- R8: The hold count restarts at zero with every new grant, so each new grant gets the full 8-cycle allowance.
- R9: While a grant's request stays high and its hold limit has not been reached, that grant stays high and unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock (100 MHz in the target system) |
| rst | input | 1 | Asynchronous active-high reset |
| req | input | 4 | Request lines, bit i from requester i |
| grant | output | 4 | Grant lines, one-hot or all zero |

## Verification
The embedded assertions check the following on every cycle:
- the grant vector stays one-hot or zero;
- a holder whose request is low loses its grant on the next edge;
- the timeout releases the holder once the count reaches its limit;
- a new grant always starts from a zero count;
- a grant only rises for a line that was requesting;
- the line just released is never the next one granted.

Only the directed scenarios can show the rest:
- the exact eight-cycle length of a held grant;
- the idle edge when the barred line is the only requester;
- the round-robin order, including the wrap-around;
- the fact that reset clears the grants before any clock edge.

// File: rtl/grant_timeout_pkg.sv
package grant_timeout_pkg;
  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic take;  // load the selected candidate as the new grant
    logic drop;  // release the current grant
  } strobe_t;
endpackage

// File: rtl/grant_timeout_ctrl.sv
module grant_timeout_ctrl
  import grant_timeout_pkg::*;
#(
  parameter int HOLD_CYCLES = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    active,
  input  logic    holderReq,
  input  logic    pickValid,
  output strobe_t strobe
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] holdCnt;

  always_comb begin
    strobe.take = !active && pickValid;
    strobe.drop = active && (!holderReq || (holdCnt == CNT_LAST));
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      holdCnt <= '0;
    end else if (strobe.take) begin
      holdCnt <= '0;
    end else if (active && !strobe.drop) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  // R8: every new grant begins with a zero count
  p_count_restart_r8: assert property (@(posedge clk) disable iff (rst)
    strobe.take |=> (holdCnt == '0));

  // R5: reaching the limit ends the grant on that edge
  p_timeout_release_r5: assert property (@(posedge clk) disable iff (rst)
    (active && holdCnt == CNT_LAST) |=> !active);
endmodule

// File: rtl/grant_timeout_path.sv
module grant_timeout_path
  import grant_timeout_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] reqIn,
  input  strobe_t            strobe,
  output logic [NUM_REQ-1:0] grantQ,
  output logic               active,
  output logic               holderReq,
  output logic               pickValid
);
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam logic [IDX_W-1:0] IDX_START = IDX_W'(NUM_REQ - 1);

  logic [NUM_REQ-1:0] barQ;
  logic [IDX_W-1:0]   lastIdx;
  logic [NUM_REQ-1:0] eligible;
  logic [NUM_REQ-1:0] pickVec;
  logic [IDX_W-1:0]   pickIdx;

  assign active    = |grantQ;
  assign holderReq = |(grantQ & reqIn);
  assign eligible  = reqIn & ~barQ;

  // Round-robin search beginning one above the last granted index.
  always_comb begin
    int cand;
    logic [IDX_W-1:0] candIdx;
    pickVec   = '0;
    pickValid = 1'b0;
    pickIdx   = '0;
    for (int off = 1; off <= NUM_REQ; off++) begin
      cand    = (int'(lastIdx) + off) % NUM_REQ;
      candIdx = IDX_W'(cand);
      if (!pickValid && eligible[candIdx]) begin
        pickVec[candIdx] = 1'b1;
        pickValid        = 1'b1;
        pickIdx          = candIdx;
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      grantQ  <= '0;
      barQ    <= '0;
      lastIdx <= IDX_START;
    end else if (strobe.drop) begin
      grantQ <= '0;
      barQ   <= grantQ;
    end else if (!active) begin
      barQ <= '0;
      if (strobe.take) begin
        grantQ  <= pickVec;
        lastIdx <= pickIdx;
      end
    end
  end

  // R3: never more than one grant
  p_onehot_grant_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grantQ));

  // R4: holder whose request is low loses the grant on the next edge
  p_req_low_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (|(grantQ & ~reqIn)) |=> (grantQ == '0));

  // R2: a grant only rises for a line that was requesting
  p_grant_requested_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(grantQ) == '0 && grantQ != '0) |-> ((grantQ & $past(reqIn)) == grantQ));

  // R6: the line released last is not the next one granted
  p_no_regrant_r6: assert property (@(posedge clk) disable iff (rst)
    (grantQ == '0 && $past(grantQ) != '0) |=> (grantQ != $past(grantQ, 2)));
endmodule

// File: rtl/grant_timeout_arb.sv
module grant_timeout_arb
  import grant_timeout_pkg::*;
#(
  parameter int NUM_REQ     = 4,
  parameter int HOLD_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] grant
);
  strobe_t strobe;
  logic    active;
  logic    holderReq;
  logic    pickValid;

  grant_timeout_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .holderReq (holderReq),
    .pickValid (pickValid),
    .strobe    (strobe)
  );

  grant_timeout_path #(.NUM_REQ(NUM_REQ)) path_i (
    .clk       (clk),
    .rst       (rst),
    .reqIn     (req),
    .strobe    (strobe),
    .grantQ    (grant),
    .active    (active),
    .holderReq (holderReq),
    .pickValid (pickValid)
  );
endmodule

// File: tb/grant_timeout_arb_tb_top.sv
module grant_timeout_arb_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = 4'b0000;
  logic [3:0] grant;
  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  grant_timeout_arb dut_i (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .grant (grant)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    req = 4'b0000;
    rst = 1'b1;
    #1 chk("R1 reset clears grants", grant, 4'b0000);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // R2 R5 R6 R8 R9: a lone requester that keeps requesting
  task automatic testTimeout();
    doReset();
    req = 4'b0001;
    step();
    chk("R2 grant follows request", grant, 4'b0001);
    for (int k = 1; k < 8; k++) begin
      step();
      chk("R9 grant held while requested", grant, 4'b0001);
    end
    step();
    chk("R5 released after 8 cycles", grant, 4'b0000);
    step();
    chk("R6 sole barred requester waits", grant, 4'b0000);
    step();
    chk("R6 regranted on following edge", grant, 4'b0001);
    for (int k = 1; k < 8; k++) begin
      step();
      chk("R8 full allowance on new grant", grant, 4'b0001);
    end
    step();
    chk("R8 second grant also ends at 8", grant, 4'b0000);
  endtask

  // R4: request drops while held
  task automatic testDrop();
    doReset();
    req = 4'b0010;
    step();
    chk("R2 grant on line 1", grant, 4'b0010);
    step();
    step();
    chk("R9 still held", grant, 4'b0010);
    req = 4'b0100;
    step();
    chk("R4 drop with no same-edge grant", grant, 4'b0000);
    step();
    chk("R4 next selection grants line 2", grant, 4'b0100);
  endtask

  // R7 R3: round-robin order with wrap-around
  task automatic testRoundRobin();
    doReset();
    req = 4'b1111;
    step();
    chk("R7 first search starts at 0", grant, 4'b0001);
    req = 4'b1110;
    step();
    chk("R4 line 0 released", grant, 4'b0000);
    step();
    chk("R7 next after 0 is 1", grant, 4'b0010);
    req = 4'b1101;
    step();
    step();
    chk("R7 next after 1 is 2 not 0", grant, 4'b0100);
    req = 4'b1011;
    step();
    step();
    chk("R7 next after 2 is 3", grant, 4'b1000);
    req = 4'b0111;
    step();
    step();
    chk("R7 wrap from 3 to 0", grant, 4'b0001);
    chk("R3 single grant", 4'($countones(grant) > 1), 4'b0000);
  endtask

  // R1: asynchronous reset
  task automatic testAsyncReset();
    doReset();
    req = 4'b0100;
    step();
    chk("R2 grant on line 2", grant, 4'b0100);
    #1 rst = 1'b1;
    #0.5 chk("R1 async clear", grant, 4'b0000);
    @(negedge clk);
    req = 4'b0000;
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    testTimeout();
    testDrop();
    testRoundRobin();
    testAsyncReset();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule